// File: doc/BRIEF.md
# Serial Port Register Bank with Byte FIFOs

This block is the software-visible side of a byte-oriented serial port. A processor reaches it over a simple 32-bit register bus with per-byte enables and a 64-word (0x100-byte) window. The bank holds six control and status words and two byte queues. One queue carries transmit bytes out to a serializer through a valid/ready stream, and the other collects received bytes from a deserializer through a second valid/ready stream. One level interrupt output tells software that an enabled event flag is pending.

Software writes bytes into the transmit queue and pops received bytes by reading a data word. It acknowledges events by writing zeros into the status flags it wants to clear. It can empty either queue through a FIFO control word, but only when that word's enable bit is also set. The line and baud words are plain storage that a serializer outside this block can decode. Read data is combinational from the current state. Every register update, push and pop takes effect at the rising clock edge.

Top module: `sio_regbank`

## Requirements
- R1: While reset is asserted and after it, the line word reads 0x40000000, the baud word reads 0x03FF0000, and the interrupt control, interrupt status and FIFO control words read 0. Both queues are empty.
- R2: After a write, each word holds only its writable bits. The masks are line 0xE17F0000, interrupt control 0x000F0000, interrupt status 0x00070000, FIFO control 0x001F0000 and baud 0x03FF0000. The line status word always reads 0 and ignores writes.
- R3: bus_be[j] qualifies data bits [8j+7:8j], so byte address offset k within a word is lane bus_be[3-k]. A write changes only the enabled lanes.
- R4: The word index is bus_waddr = byte offset / 4. The byte offsets are line 0, line status 4, interrupt control 8, interrupt status 12, FIFO control 16, baud 20, transmit data 32 and receive data 48.
- R5: A status write ANDs each enabled lane of the write data into the stored flags, so a 0 clears a flag and a 1 keeps it. A write never sets a flag.
- R6: The receive flag is status bit 16, and it is set at each edge at which the receive queue was non-empty before the edge. The transmit flag is status bit 17, and it is set at each edge at which the transmit queue was empty before the edge. This setting takes priority over a clear in the same cycle, and both flags persist until cleared.
- R7: irq is high exactly when any of status bits 18:16 ANDed with control bits 18:16 is 1. The enable bits are 18 for error, 17 for transmit and 16 for receive.
- R8: In a FIFO control write, bit 18 empties the transmit queue and bit 17 empties the receive queue, at that edge, but only when the resulting word has bit 16 set. A flush wins over a push or pop in the same cycle.
- R9: A write to offset 32 with bus_be[3] set pushes bus_wdata[31:24]. A push into a full queue is dropped, with fullness judged before the edge. The queue drives tx_valid/tx_data in order and pops on tx_valid and tx_ready. Offset 32 always reads 0.
- R10: rx_ready is low while the receive queue is full. A read at offset 48 returns the oldest byte in bits 31:24 and pops it only when bus_be[3] is set. An empty receive queue reads 0.
- R11: Offsets not listed in R4 read 0 and ignore writes. Control bit 19 is stored and read back, with no other effect.
- R12: Each queue holds FIFO_DEPTH bytes (8 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 6 | Word index (byte offset / 4) |
| bus_be | input | 4 | Byte lane enables, bit j for bits 8j+7:8j |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| irq | output | 1 | Level interrupt |
| tx_data | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit queue non-empty |
| tx_ready | input | 1 | Sink accepts tx_data this cycle |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | rx_data is valid |
| rx_ready | output | 1 | Receive queue has space |

## Verification
The bench first tries the register words with full-word writes and with single-lane writes. This separates the per-word masks from the lane placement, and it shows whether read-only and unmapped words stay at zero. Status clears are tried twice: once while the transmit queue is empty, where the flag must come straight back, and once while it holds data, where the clear must stick. This exposes whether set or clear wins in the same cycle. The queues are filled past capacity with the sink and source stalled, and then drained. This checks ordering, dropped pushes, back-pressure and pops that depend on the lane. FIFO control writes with the enable bit clear and then set show whether the flush is gated.

// File: rtl/sio_regbank_pkg.sv
package sio_regbank_pkg;

    localparam int unsigned BUS_W   = 32;
    localparam int unsigned LANES   = BUS_W / 8;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned WADDR_W = 6;

    typedef enum logic [WADDR_W-1:0] {
        W_LINE  = 6'd0,
        W_LSTAT = 6'd1,
        W_ICTL  = 6'd2,
        W_ISTAT = 6'd3,
        W_FCTL  = 6'd4,
        W_BAUD  = 6'd5,
        W_TXBUF = 6'd8,
        W_RXBUF = 6'd12
    } word_sel_e;

    localparam logic [BUS_W-1:0] LINE_MASK  = 32'hE17F_0000;
    localparam logic [BUS_W-1:0] ICTL_MASK  = 32'h000F_0000;
    localparam logic [BUS_W-1:0] ISTAT_MASK = 32'h0007_0000;
    localparam logic [BUS_W-1:0] FCTL_MASK  = 32'h001F_0000;
    localparam logic [BUS_W-1:0] BAUD_MASK  = 32'h03FF_0000;

    localparam logic [BUS_W-1:0] LINE_RST = 32'h4000_0000;
    localparam logic [BUS_W-1:0] BAUD_RST = 32'h03FF_0000;

    // event flag / enable positions share one layout
    localparam int unsigned EV_RX  = 16;
    localparam int unsigned EV_TX  = 17;
    localparam int unsigned EV_ERR = 18;

    localparam int unsigned FC_EN  = 16;
    localparam int unsigned FC_RXF = 17;
    localparam int unsigned FC_TXF = 18;

    // data moves on the most significant lane (byte offset 0)
    localparam int unsigned DATA_LANE = LANES - 1;

    typedef struct packed {
        logic [BUS_W-1:0] line;
        logic [BUS_W-1:0] ictl;
        logic [BUS_W-1:0] istat;
        logic [BUS_W-1:0] fctl;
        logic [BUS_W-1:0] baud;
    } csr_state_t;

    function automatic logic [BUS_W-1:0] lane_bits(input logic [LANES-1:0] be);
        logic [BUS_W-1:0] m;
        m = '0;
        for (int j = 0; j < LANES; j++) begin
            m[8*j +: 8] = {8{be[j]}};
        end
        return m;
    endfunction

    function automatic logic [BUS_W-1:0] lane_merge(
        input logic [BUS_W-1:0] old,
        input logic [BUS_W-1:0] wdata,
        input logic [LANES-1:0] be,
        input logic [BUS_W-1:0] mask
    );
        logic [BUS_W-1:0] sel;
        sel = lane_bits(be);
        return mask & ((old & ~sel) | (wdata & sel));
    endfunction

    function automatic logic [BUS_W-1:0] lane_and(
        input logic [BUS_W-1:0] old,
        input logic [BUS_W-1:0] wdata,
        input logic [LANES-1:0] be,
        input logic [BUS_W-1:0] mask
    );
        logic [BUS_W-1:0] sel;
        sel = lane_bits(be);
        return mask & old & (wdata | ~sel);
    endfunction

    function automatic logic event_pending(input csr_state_t s);
        return |(s.istat[EV_ERR:EV_RX] & s.ictl[EV_ERR:EV_RX]);
    endfunction

endpackage

// File: rtl/sio_byte_fifo.sv
module sio_byte_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            slots[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // a push into a full queue leaves the occupancy unchanged
    p_full_drop_r12: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> (count == $past(count)));

    // popping an empty queue cannot underflow it
    p_empty_pop_r10: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push && !flush) |=> empty);

endmodule

// File: rtl/sio_ctrl_regs.sv
module sio_ctrl_regs
    import sio_regbank_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  word_sel_e          wr_word,
    input  logic [LANES-1:0]   wr_be,
    input  logic [BUS_W-1:0]   wr_data,
    input  logic               tx_empty,
    input  logic               rx_nonempty,
    output csr_state_t         csr,
    output logic               tx_flush,
    output logic               rx_flush
);
    csr_state_t csr_q, csr_d;

    always_comb begin
        csr_d    = csr_q;
        tx_flush = 1'b0;
        rx_flush = 1'b0;
        if (wr_en) begin
            case (wr_word)
                W_LINE:  csr_d.line  = lane_merge(csr_q.line,  wr_data, wr_be, LINE_MASK);
                W_ICTL:  csr_d.ictl  = lane_merge(csr_q.ictl,  wr_data, wr_be, ICTL_MASK);
                W_ISTAT: csr_d.istat = lane_and(csr_q.istat,   wr_data, wr_be, ISTAT_MASK);
                W_BAUD:  csr_d.baud  = lane_merge(csr_q.baud,  wr_data, wr_be, BAUD_MASK);
                W_FCTL: begin
                    csr_d.fctl = lane_merge(csr_q.fctl, wr_data, wr_be, FCTL_MASK);
                    if (csr_d.fctl[FC_EN]) begin
                        tx_flush = csr_d.fctl[FC_TXF];
                        rx_flush = csr_d.fctl[FC_RXF];
                    end
                end
                default: ;
            endcase
        end
        // queue state seen before the edge re-arms the flags after any clear
        if (rx_nonempty) csr_d.istat[EV_RX] = 1'b1;
        if (tx_empty)    csr_d.istat[EV_TX] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_q <= '{line: LINE_RST, ictl: '0, istat: '0, fctl: '0, baud: BAUD_RST};
        end else begin
            csr_q <= csr_d;
        end
    end

    assign csr = csr_q;

    // with no queue event, flags can only fall
    p_flags_only_fall_r5: assert property (@(posedge clk) disable iff (rst)
        (!rx_nonempty && !tx_empty) |=> ((csr_q.istat & ~$past(csr_q.istat)) == '0));

endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
    import sio_regbank_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bus_sel,
    input  logic         bus_we,
    input  logic [5:0]   bus_waddr,
    input  logic [3:0]   bus_be,
    input  logic [31:0]  bus_wdata,
    output logic [31:0]  bus_rdata,
    output logic         irq,
    output logic [7:0]   tx_data,
    output logic         tx_valid,
    input  logic         tx_ready,
    input  logic [7:0]   rx_data,
    input  logic         rx_valid,
    output logic         rx_ready
);
    word_sel_e   word;
    logic        wr_en, rd_en;
    logic        tx_push, tx_flush, tx_empty, tx_full;
    logic        rx_pop, rx_flush, rx_empty, rx_full;
    logic [BYTE_W-1:0] rx_head;
    csr_state_t  csr;

    assign word    = word_sel_e'(bus_waddr);
    assign wr_en   = bus_sel && bus_we;
    assign rd_en   = bus_sel && !bus_we;
    assign tx_push = wr_en && (word == W_TXBUF) && bus_be[DATA_LANE];
    assign rx_pop  = rd_en && (word == W_RXBUF) && bus_be[DATA_LANE];

    sio_ctrl_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_word     (word),
        .wr_be       (bus_be),
        .wr_data     (bus_wdata),
        .tx_empty    (tx_empty),
        .rx_nonempty (!rx_empty),
        .csr         (csr),
        .tx_flush    (tx_flush),
        .rx_flush    (rx_flush)
    );

    sio_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_txq (
        .clk       (clk),
        .rst       (rst),
        .flush     (tx_flush),
        .push      (tx_push),
        .push_data (bus_wdata[BUS_W-1 -: BYTE_W]),
        .pop       (tx_ready),
        .head      (tx_data),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    sio_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .flush     (rx_flush),
        .push      (rx_valid),
        .push_data (rx_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    assign tx_valid = !tx_empty;
    assign rx_ready = !rx_full;
    assign irq      = event_pending(csr);

    always_comb begin
        bus_rdata = '0;
        case (word)
            W_LINE:  bus_rdata = csr.line;
            W_ICTL:  bus_rdata = csr.ictl;
            W_ISTAT: bus_rdata = csr.istat;
            W_FCTL:  bus_rdata = csr.fctl;
            W_BAUD:  bus_rdata = csr.baud;
            W_RXBUF: if (!rx_empty) bus_rdata[BUS_W-1 -: BYTE_W] = rx_head;
            default: ;
        endcase
    end

    // an empty transmit queue raises its flag at the next edge
    p_txflag_set_r6: assert property (@(posedge clk) disable iff (rst)
        !tx_valid |=> csr.istat[EV_TX]);

    p_rxflag_set_r6: assert property (@(posedge clk) disable iff (rst)
        !rx_empty |=> csr.istat[EV_RX]);

    // an enabled transmit flush leaves nothing to send
    p_flush_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && word == W_FCTL && bus_be[2] && bus_wdata[FC_EN] && bus_wdata[FC_TXF])
        |=> !tx_valid);

    // clearing all flags sticks when no queue event re-arms them
    p_flag_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && word == W_ISTAT && bus_be[2] && bus_wdata[EV_ERR:EV_RX] == 3'b000
         && tx_valid && rx_empty) |=> (csr.istat[EV_ERR:EV_RX] == 3'b000));

    // a full transmit queue with a stalled sink stays full
    p_tx_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_full && !tx_ready && !tx_flush) |=> tx_full);

endmodule

// File: tb/sio_regbank_bench.sv
`timescale 1ns/1ps
module sio_regbank_bench;
    localparam int DEPTH = 8;
    localparam int WD_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        b_sel, b_we;
    int          b_off;
    logic [3:0]  b_be;
    logic [31:0] b_wdata;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_ready;
    logic [7:0]  rx_data;
    logic        rx_valid, rx_ready;
    logic [5:0]  bus_waddr;

    always #2.5 clk = ~clk;
    assign bus_waddr = b_off[7:2];

    sio_regbank #(.FIFO_DEPTH(DEPTH)) u_sio_regbank (
        .clk(clk), .rst(rst), .bus_sel(b_sel), .bus_we(b_we), .bus_waddr(bus_waddr),
        .bus_be(b_be), .bus_wdata(b_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
    );

    // reference model state
    logic [31:0] m_lcr, m_ictl, m_istat, m_fctl, m_baud;
    logic [7:0]  m_txq[$];
    logic [7:0]  m_rxq[$];

    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] put_lanes(logic [31:0] old, logic [31:0] wd, logic [3:0] be);
        logic [31:0] r;
        r = old;
        for (int j = 0; j < 4; j++) if (be[j]) r[8*j +: 8] = wd[8*j +: 8];
        return r;
    endfunction

    function automatic logic [31:0] model_read(int off);
        case (off)
            0:  return m_lcr;
            8:  return m_ictl;
            12: return m_istat;
            16: return m_fctl;
            20: return m_baud;
            48: return (m_rxq.size() != 0) ? {m_rxq[0], 24'h0} : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag(int off);
        case (off)
            0, 8, 16, 20: return "R4 register read";
            4:  return "R2 line status read";
            12: return "R6 status read";
            32: return "R9 tx word read";
            48: return "R10 rx word read";
            default: return "R11 undefined read";
        endcase
    endfunction

    task automatic model_step();
        int txn, rxn;
        logic tfl, rfl;
        txn = m_txq.size();
        rxn = m_rxq.size();
        tfl = 1'b0;
        rfl = 1'b0;
        if (b_sel && b_we) begin
            case (b_off)
                0:  m_lcr  = put_lanes(m_lcr,  b_wdata, b_be) & 32'hE17F0000;
                8:  m_ictl = put_lanes(m_ictl, b_wdata, b_be) & 32'h000F0000;
                12: begin
                    for (int j = 0; j < 4; j++)
                        if (b_be[j]) m_istat[8*j +: 8] = m_istat[8*j +: 8] & b_wdata[8*j +: 8];
                    m_istat = m_istat & 32'h00070000;
                end
                16: begin
                    m_fctl = put_lanes(m_fctl, b_wdata, b_be) & 32'h001F0000;
                    if (m_fctl[16]) begin
                        tfl = m_fctl[18];
                        rfl = m_fctl[17];
                    end
                end
                20: m_baud = put_lanes(m_baud, b_wdata, b_be) & 32'h03FF0000;
                32: if (b_be[3] && txn < DEPTH) m_txq.push_back(b_wdata[31:24]);
                default: ;
            endcase
        end
        if (b_sel && !b_we && b_off == 48 && b_be[3] && rxn > 0) void'(m_rxq.pop_front());
        if (tx_ready && txn > 0) void'(m_txq.pop_front());
        if (rx_valid && rxn < DEPTH) m_rxq.push_back(rx_data);
        if (tfl) m_txq.delete();
        if (rfl) m_rxq.delete();
        if (rxn > 0)  m_istat[16] = 1'b1;
        if (txn == 0) m_istat[17] = 1'b1;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_lcr = 32'h40000000; m_ictl = 0; m_istat = 0; m_fctl = 0; m_baud = 32'h03FF0000;
            m_txq.delete(); m_rxq.delete();
        end else begin
            model_step();
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check("R7 irq level", {31'b0, irq}, {31'b0, |(m_istat[18:16] & m_ictl[18:16])});
            check("R9 tx_valid", {31'b0, tx_valid}, {31'b0, m_txq.size() != 0});
            if (m_txq.size() != 0) check("R9 tx_data order", {24'b0, tx_data}, {24'b0, m_txq[0]});
            check("R10 rx_ready", {31'b0, rx_ready}, {31'b0, m_rxq.size() < DEPTH});
            if (b_sel && !b_we) check(rd_tag(b_off), bus_rdata, model_read(b_off));
        end
    end

    task automatic bus_write(int off, logic [3:0] be, logic [31:0] wd);
        @(posedge clk); #1;
        b_sel = 1'b1; b_we = 1'b1; b_off = off; b_be = be; b_wdata = wd;
        @(posedge clk); #1;
        b_sel = 1'b0; b_we = 1'b0;
    endtask

    task automatic read_expect(int off, logic [3:0] be, logic [31:0] exp, string tag);
        @(posedge clk); #1;
        b_sel = 1'b1; b_we = 1'b0; b_off = off; b_be = be;
        @(negedge clk);
        check(tag, bus_rdata, exp);
        @(posedge clk); #1;
        b_sel = 1'b0;
    endtask

    task automatic sig_expect(logic act, logic exp, string tag);
        @(negedge clk);
        check(tag, {31'b0, act}, {31'b0, exp});
    endtask

    task automatic rx_feed(int n, logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            rx_valid = 1'b1; rx_data = base + 8'(i);
        end
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R1-to-end run actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] got[$];
        rst = 1'b1; b_sel = 0; b_we = 0; b_off = 0; b_be = 0; b_wdata = 0;
        tx_ready = 0; rx_valid = 0; rx_data = 0;
        repeat (3) @(posedge clk);
        read_expect(0,  4'hF, 32'h40000000, "R1 line reset");
        read_expect(20, 4'hF, 32'h03FF0000, "R1 baud reset");
        read_expect(8,  4'hF, 32'h0, "R1 control reset");
        read_expect(12, 4'hF, 32'h0, "R1 status reset");
        sig_expect(tx_valid, 1'b0, "R1 tx queue empty");
        @(posedge clk); #1; rst = 1'b0;
        repeat (3) @(posedge clk);

        read_expect(12, 4'hF, 32'h00020000, "R6 tx flag after reset");
        bus_write(0, 4'hF, 32'hFFFFFFFF);
        read_expect(0, 4'hF, 32'hE17F0000, "R2 line mask");
        bus_write(0, 4'b1000, 32'h00000000);
        read_expect(0, 4'hF, 32'h007F0000, "R3 single lane line");
        bus_write(20, 4'b0100, 32'h00AA0000);
        read_expect(20, 4'hF, 32'h03AA0000, "R3 single lane baud");
        bus_write(4, 4'hF, 32'hFFFFFFFF);
        read_expect(4, 4'hF, 32'h0, "R2 line status read-only");
        bus_write(64, 4'hF, 32'hFFFFFFFF);
        read_expect(64, 4'hF, 32'h0, "R11 undefined offset");
        bus_write(8, 4'hF, 32'hFFFFFFFF);
        read_expect(8, 4'hF, 32'h000F0000, "R11 dma bit stored");
        sig_expect(irq, 1'b1, "R7 irq on tx flag");
        bus_write(12, 4'b0100, 32'h0);
        read_expect(12, 4'hF, 32'h00020000, "R6 set wins over clear");

        bus_write(32, 4'b1000, 32'h11000000);
        bus_write(32, 4'b1000, 32'h22000000);
        bus_write(32, 4'b1000, 32'h33000000);
        bus_write(32, 4'b0111, 32'h44FFFFFF);
        sig_expect(tx_valid, 1'b1, "R9 tx queue holds data");
        check("R9 tx head byte", {24'b0, tx_data}, 32'h11);
        bus_write(12, 4'b0100, 32'h0);
        read_expect(12, 4'hF, 32'h0, "R5 clear sticks");
        sig_expect(irq, 1'b0, "R7 irq low after clear");
        bus_write(12, 4'hF, 32'hFFFFFFFF);
        read_expect(12, 4'hF, 32'h0, "R5 ones do not set");

        for (int i = 0; i < 6; i++) bus_write(32, 4'b1000, {8'h55 + 8'(17 * i), 24'h0});
        @(posedge clk); #1; tx_ready = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (tx_valid) got.push_back(tx_data);
        end
        @(posedge clk); #1; tx_ready = 1'b0;
        check("R12 drained count", got.size(), DEPTH);
        if (got.size() == DEPTH) begin
            check("R9 first out", {24'b0, got[0]}, 32'h11);
            check("R9 last out, extra push dropped", {24'b0, got[7]}, 32'h99);
        end
        sig_expect(irq, 1'b1, "R7 irq after drain");

        rx_feed(12, 8'hA0);
        sig_expect(rx_ready, 1'b0, "R10 backpressure when full");
        read_expect(48, 4'b0111, 32'hA0000000, "R10 peek without pop");
        for (int i = 0; i < 8; i++)
            read_expect(48, 4'b1000, {8'hA0 + 8'(i), 24'h0}, "R10 pop order");
        read_expect(48, 4'b1000, 32'h0, "R10 empty reads zero");
        read_expect(12, 4'hF, 32'h00030000, "R6 rx flag sticky");

        bus_write(32, 4'b1000, 32'h5A000000);
        bus_write(32, 4'b1000, 32'h5B000000);
        bus_write(16, 4'b0100, 32'h00040000);
        sig_expect(tx_valid, 1'b1, "R8 flush needs enable");
        bus_write(16, 4'b0100, 32'h00050000);
        sig_expect(tx_valid, 1'b0, "R8 tx flush");
        rx_feed(2, 8'hC1);
        bus_write(16, 4'b0100, 32'h00030000);
        read_expect(48, 4'b1000, 32'h0, "R8 rx flush");
        read_expect(16, 4'hF, 32'h00030000, "R2 fifo control readback");
        read_expect(32, 4'hF, 32'h0, "R9 tx word reads zero");

        repeat (3) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule